// File: doc/BRIEF.md
# Dual-Mode Booth Integer Multiplier

This block is an unsigned integer multiplier that works in one of two modes, chosen by a mode input on each operand pair. In double mode it forms the full product of one pair of 54-bit operands. In dual mode it forms two independent 24x24 products, one for each operand lane, in the same pass. Both modes use the same radix-4 Booth partial-product rows and the same adder tree. The tree's adders break their carry at the mid-word boundary when in dual mode, so the two lanes stay isolated.

Operands arrive as two packed 64-bit words, and the result leaves as one packed 128-bit word. A parameter sets one or two register stages. With two stages, a register splits the adder tree after its second level. The mode bit travels down the pipeline alongside its operands, so double and dual requests can be mixed on every cycle. The block feeds mantissa datapaths that must serve either one wide lane or two narrow lanes.

Top module: `dm_booth_mul`

## Requirements
- R1: With `dual_i` = 0 (double mode), `p_o[107:0]` equals `a_i[53:0] * b_i[53:0]` as unsigned numbers, and `p_o[127:108]` is zero.
- R2: With `dual_i` = 1 (dual mode), `p_o[47:0]` equals `a_i[23:0] * b_i[23:0]`, and `p_o[63:48]` is zero.
- R3: With `dual_i` = 1, `p_o[111:64]` equals `a_i[55:32] * b_i[55:32]`, and `p_o[127:112]` is zero.
- R4: Operand bits outside the active fields have no effect on `p_o`. These are bits 63:54 in double mode, and bits 31:24 and 63:56 in dual mode.
- R5: In dual mode, neither lane's partial products nor its carries reach the other lane. An all-ones lane next to a zero lane leaves the zero lane's product field at zero.
- R6: The product for an operand pair appears on `p_o` exactly `STAGES` rising clock edges after the pair is applied (default 2). A new pair, in either mode, is accepted on every cycle.
- R7: While `rst_ni` is low, `p_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_i | input | 1 | 0: one 54x54 product; 1: two 24x24 lane products |
| a_i | input | 64 | Multiplicand word (double field 53:0, lanes 23:0 and 55:32) |
| b_i | input | 64 | Multiplier word (same field layout as `a_i`) |
| p_o | output | 128 | Product word (double 107:0; lanes 47:0 and 111:64) |

## Verification
The hardest case to reach is a lane-boundary leak. Negative Booth rows in the low lane sign-extend up to bit 63, and their wrap-around carry must be dropped rather than passed into the high lane. A leak of this kind corrupts the high lane only when the low lane produces many negative digits. The stimulus therefore pairs all-ones low-lane operands, which recode to many -1 digits, with a zero or small high lane, and the reverse. It also streams random operand pairs whose mode changes cycle by cycle, so that a pipelined mode bit out of step with its data shows up as a wrong lane layout.

// File: rtl/dm_mul_pkg.sv
package dm_mul_pkg;

  typedef enum logic {
    MODE_DBL  = 1'b0,
    MODE_DUAL = 1'b1
  } mul_mode_e;

  function automatic int pow2_ceil(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/dm_booth_rows.sv
// Radix-4 Booth recoding and partial-product rows for both modes.
module dm_booth_rows #(
  parameter int DBL_W  = 54,
  parameter int SGL_W  = 24,
  parameter int WORD_W = 64,
  parameter int NROWS  = 32
) (
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  input  logic                dual_i,
  output logic [2*WORD_W-1:0] rows_o [NROWS]
);
  localparam int PW   = 2 * WORD_W;
  localparam int HALF = WORD_W / 2;
  localparam int LD   = (SGL_W + 2) / 2;  // digits per lane, one zero bit on top
  localparam int ND   = (DBL_W + 2) / 2;  // digits in double mode
  localparam int BXW  = 2 * ND;

  logic [BXW-1:0] bx_dbl, bx_dual;
  logic [BXW:0]   rb;
  logic [PW-1:0]  m_dbl, m_l0, m_l1;

  assign bx_dbl  = BXW'(b_i[DBL_W-1:0]);
  // low lane in digits 0..LD-1, high lane starts at digit LD with a zero guard below
  assign bx_dual = (BXW'(b_i[HALF +: SGL_W]) << (2 * LD)) | BXW'(b_i[SGL_W-1:0]);
  assign rb      = {(dual_i ? bx_dual : bx_dbl), 1'b0};

  assign m_dbl = PW'(a_i[DBL_W-1:0]);
  assign m_l0  = PW'(a_i[SGL_W-1:0]);
  assign m_l1  = PW'(a_i[HALF +: SGL_W]);

  logic unused_hi;
  assign unused_hi = ^{a_i[WORD_W-1:DBL_W], b_i[WORD_W-1:DBL_W]};

  for (genvar i = 0; i < NROWS; i++) begin : g_row
    if (i < ND) begin : g_live
      localparam int SH_S = (i < LD) ? 2 * i : 2 * (i - LD) + WORD_W;
      logic [2:0]    trip;
      logic          one, two, neg;
      logic [PW-1:0] m_s, x, mag, r;

      assign trip = rb[2*i +: 3];
      assign one  = trip[1] ^ trip[0];
      assign two  = (trip == 3'b100) || (trip == 3'b011);
      assign neg  = trip[2] & ~(trip[1] & trip[0]);

      if (i < LD) begin : g_l0
        assign m_s = m_l0;
      end else begin : g_l1
        assign m_s = m_l1;
      end

      assign x   = dual_i ? (m_s << SH_S) : (m_dbl << (2 * i));
      assign mag = two ? (x << 1) : (one ? x : '0);
      assign r   = neg ? (~mag + PW'(1)) : mag;

      if (i < LD) begin : g_mask
        // low-lane rows keep their sign extension below the lane boundary
        assign rows_o[i] = dual_i ? {{WORD_W{1'b0}}, r[WORD_W-1:0]} : r;
      end else begin : g_pass
        assign rows_o[i] = r;
      end
    end else begin : g_pad
      assign rows_o[i] = '0;
    end
  end

endmodule

// File: rtl/dm_seg_add.sv
// Adder whose carry across the mid-word boundary is cut in dual mode.
module dm_seg_add #(
  parameter int PW = 128
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  input  logic          dual_i,
  output logic [PW-1:0] s_o
);
  localparam int H = PW / 2;

  logic [H:0]   lo;
  logic [H-1:0] hi;

  assign lo  = {1'b0, a_i[H-1:0]} + {1'b0, b_i[H-1:0]};
  assign hi  = a_i[PW-1:H] + b_i[PW-1:H] + H'(~dual_i & lo[H]);
  assign s_o = {hi, lo[H-1:0]};

endmodule

// File: rtl/dm_seg_tree.sv
// Binary reduction tree of segmented adders, optional register after level CUT.
module dm_seg_tree #(
  parameter int PW     = 128,
  parameter int NROWS  = 32,
  parameter int STAGES = 2,
  parameter int CUT    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] rows_i [NROWS],
  input  logic          dual_i,
  output logic [PW-1:0] sum_o,
  output logic          dual_o
);
  localparam int LV = $clog2(NROWS);

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int N = NROWS >> l;
    logic [PW-1:0] row [N];
    logic          dual;

    if (l == 0) begin : g_in
      assign row  = rows_i;
      assign dual = dual_i;
    end else begin : g_add
      logic [PW-1:0] s [N];
      for (genvar j = 0; j < N; j++) begin : g_node
        dm_seg_add #(.PW(PW)) u_add (
          .a_i   (g_lv[l-1].row[2*j]),
          .b_i   (g_lv[l-1].row[2*j+1]),
          .dual_i(g_lv[l-1].dual),
          .s_o   (s[j])
        );
      end
      if (STAGES > 1 && l == CUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            for (int j = 0; j < N; j++) row[j] <= '0;
            dual <= 1'b0;
          end else begin
            for (int j = 0; j < N; j++) row[j] <= s[j];
            dual <= g_lv[l-1].dual;
          end
        end
      end else begin : g_wire
        assign row  = s;
        assign dual = g_lv[l-1].dual;
      end
    end
  end

  assign sum_o  = g_lv[LV].row[0];
  assign dual_o = g_lv[LV].dual;

endmodule

// File: rtl/dm_booth_mul.sv
module dm_booth_mul
  import dm_mul_pkg::*;
#(
  parameter int DBL_W  = 54,
  parameter int SGL_W  = 24,
  parameter int WORD_W = 64,
  parameter int STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dual_i,
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  output logic [2*WORD_W-1:0] p_o
);
  localparam int PW    = 2 * WORD_W;
  localparam int LD    = (SGL_W + 2) / 2;
  localparam int ND    = (DBL_W + 2) / 2;
  localparam int NROWS = pow2_ceil(ND);
  localparam int LV    = $clog2(NROWS);
  localparam int CUT   = (LV > 2) ? 2 : 1;

  logic [PW-1:0] rows [NROWS];
  logic [PW-1:0] sum;
  logic          dual_t;
  logic [PW-1:0] p_q;
  logic          dual_q;
  logic          in_dual;

  assign in_dual = (mul_mode_e'(dual_i) == MODE_DUAL);

  dm_booth_rows #(
    .DBL_W (DBL_W),
    .SGL_W (SGL_W),
    .WORD_W(WORD_W),
    .NROWS (NROWS)
  ) u_rows (
    .a_i   (a_i),
    .b_i   (b_i),
    .dual_i(in_dual),
    .rows_o(rows)
  );

  dm_seg_tree #(
    .PW    (PW),
    .NROWS (NROWS),
    .STAGES(STAGES),
    .CUT   (CUT)
  ) u_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rows_i(rows),
    .dual_i(in_dual),
    .sum_o (sum),
    .dual_o(dual_t)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q    <= '0;
      dual_q <= 1'b0;
    end else begin
      p_q    <= sum;
      dual_q <= dual_t;
    end
  end

  assign p_o = p_q;

  // Output layout per mode
  p_dbl_top_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_q |-> (p_o[PW-1:2*DBL_W] == '0));
  p_lane0_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_q |-> (p_o[WORD_W-1:2*SGL_W] == '0));
  p_lane1_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_q |-> (p_o[PW-1:WORD_W+2*SGL_W] == '0));

  // Lane isolation of the partial-product rows
  for (genvar i = 0; i < ND; i++) begin : g_chk
    if (i < LD) begin : g_lo
      p_row_lane0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_dual |-> (rows[i][PW-1:WORD_W] == '0));
    end else begin : g_hi
      p_row_lane1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_dual |-> (rows[i][WORD_W-1:0] == '0));
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) p_reset_clear_r7: assert (p_o == '0);
  end

endmodule

// File: tb/dm_booth_mul_bench.sv
module dm_booth_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam int NSTREAM = 120;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dual_i = 1'b0;
  logic [63:0]  a_i = '0, b_i = '0;
  logic [127:0] p_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_booth_mul #(.STAGES(LAT)) u_dm_booth_mul (
    .clk_i(clk), .rst_ni(rst_ni), .dual_i(dual_i),
    .a_i(a_i), .b_i(b_i), .p_o(p_o)
  );

  function automatic logic [127:0] exp_of(input logic [63:0] a, input logic [63:0] b,
                                          input logic d);
    logic [127:0] r;
    r = '0;
    if (d) begin
      r[63:0]   = 64'(a[23:0]) * 64'(b[23:0]);
      r[127:64] = 64'(a[55:32]) * 64'(b[55:32]);
    end else begin
      r = 128'(a[53:0]) * 128'(b[53:0]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_res(input logic [127:0] got, input logic [127:0] exp, input logic d,
                         input string tag);
    if (d) begin
      chk({"R2 ", tag}, {64'b0, got[63:0]}, {64'b0, exp[63:0]});
      chk({"R3 ", tag}, {got[127:64], 64'b0}, {exp[127:64], 64'b0});
    end else begin
      chk({"R1 ", tag}, got, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] a, input logic [63:0] b, input logic d,
                         input string tag);
    @(negedge clk);
    a_i = a; b_i = b; dual_i = d;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    chk_res(p_o, exp_of(a, b, d), d, tag);
  endtask

  logic [63:0]  sa [NSTREAM];
  logic [63:0]  sb [NSTREAM];
  logic         sd [NSTREAM];

  initial begin
    void'($urandom(32'd20240611));
    // R7: output held clear during reset, even with operands applied
    a_i = '1; b_i = '1; dual_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset", p_o, '0);
    rst_ni = 1'b1;

    run_one(64'h003F_FFFF_FFFF_FFFF, 64'h003F_FFFF_FFFF_FFFF, 1'b0, "all-ones double");
    run_one(64'h0, 64'h003F_FFFF_FFFF_FFFF, 1'b0, "zero double");
    run_one(64'h003F_FFFF_FFFF_FFFF, 64'h1, 1'b0, "times one double");
    run_one(64'h0000_00FF_FFFF_FFFF, 64'h0020_0000_0000_0000, 1'b0, "top bit double");
    run_one(64'h00FF_FFFF_00FF_FFFF, 64'h00FF_FFFF_00FF_FFFF, 1'b1, "all-ones dual");
    // R5: low lane all ones, high lane zero; and the reverse
    run_one(64'h0000_0000_00FF_FFFF, 64'h0000_0000_00FF_FFFF, 1'b1, "R5 low busy");
    run_one(64'h00FF_FFFF_0000_0000, 64'h00FF_FFFF_0000_0000, 1'b1, "R5 high busy");
    run_one(64'h0000_0001_00FF_FFFF, 64'h0000_0001_00AA_AAAB, 1'b1, "R5 small high");
    // R4: junk in bits outside the active fields
    run_one(64'hFF00_0000_FF00_0000, 64'hFFAB_CDEF_FF12_3456, 1'b1, "R4 dual junk");
    run_one(64'hFFC0_0000_0000_0003, 64'hFFC0_0000_0000_0005, 1'b0, "R4 double junk");

    // R6: back-to-back stream with mixed modes
    for (int k = 0; k < NSTREAM; k++) begin
      logic [31:0] sel;
      sel = $urandom % 8;
      sa[k] = {$urandom, $urandom};
      sb[k] = {$urandom, $urandom};
      if (sel == 0) sa[k] = '1;
      if (sel == 1) sb[k] = '1;
      if (sel == 2) sa[k][31:0] = '0;
      sd[k] = 1'($urandom);
    end
    for (int k = 0; k < NSTREAM + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) chk_res(p_o, exp_of(sa[k-LAT], sb[k-LAT], sd[k-LAT]), sd[k-LAT], "R6 stream");
      if (k < NSTREAM) begin
        a_i = sa[k]; b_i = sb[k]; dual_i = sd[k];
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule